// File: doc/BRIEF.md
# I2S Audio Serial Transmitter

This block is the bus master of an I2S audio link. It derives the bit clock from the system clock, drives the word-select line and shifts out one left and one right sample per frame on a single data wire. Samples are two's-complement words handed over in parallel, one left/right pair per transfer. Each channel occupies a slot of `SLOT_W` bit clocks. The sample width `SAMPLE_W` may be smaller than the slot, in which case the slot is filled with zeros after the sample's least significant bit.

The serial outputs change on the falling edge of the bit clock, so a receiver samples them on the rising edge. Word select changes one bit clock before the MSB of the word it announces. This means every word is shifted by one bit against its channel boundary, and the last slot bit of the right channel falls into the first bit position of the next frame.

The sample input is a valid/ready stream backed by a one-entry holding buffer. `s_ready` is high exactly when that buffer is empty. A transfer takes place on any system clock edge where `s_valid` and `s_ready` are both high. The source must hold `s_valid` and the data stable while `s_ready` is low. A frame takes its pair from the buffer only at its own start. If the source keeps the buffer full, no frame ever misses data. If the buffer is empty at a frame start, the previous pair is sent again and `underrun` is raised for that frame.

Top module: `i2s_tx_master`

## Requirements
- R1: `sck` is low after reset and toggles every `HALF_DIV` system clocks, giving a period of 2*`HALF_DIV` clocks with equal high and low times.
- R2: `ws`, `sd` and `underrun` change only on the system clock edge on which `sck` falls.
- R3: A frame is 2*`SLOT_W` bit positions, counted from 0 at a falling edge of `sck`. `ws` is 0 (left channel) for positions 0 to `SLOT_W`-1 and 1 (right channel) for positions `SLOT_W` to 2*`SLOT_W`-1.
- R4: One-bit delay: the left MSB is on `sd` at position 1 and the right MSB at position `SLOT_W`+1. The final right slot bit is on `sd` at position 0 of the following frame.
- R5: Each word goes out MSB first, bit `SAMPLE_W`-1 down to bit 0, on consecutive positions.
- R6: Slot bits after the LSB of a word are driven as 0.
- R7: `s_ready` is 1 exactly while the holding buffer is empty. A transfer (`s_valid` and `s_ready` both 1 at a clock edge) fills the buffer, so `s_ready` is 0 on the next cycle.
- R8: The buffer is read on the `sck` falling edge that starts position 1. A pair present there is sent in that frame and the buffer is emptied.
- R9: If the buffer is empty at that edge, the previous pair is sent again and `underrun` is 1 for the rest of that frame. Otherwise `underrun` is 0.
- R10: After reset: `sck`=0, `ws`=1, `sd`=0, `underrun`=0, `s_ready`=1, and the held pair is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding buffer empty, pair accepted this edge if offered |
| s_left | input | SAMPLE_W | Left sample, two's complement |
| s_right | input | SAMPLE_W | Right sample, two's complement |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, 0 = left, 1 = right |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Current frame repeats the previous pair |

## Verification
Two configurations are swept over every pair of 4-bit values. One has a padded slot (6-bit slot, 4-bit word) and the other has no padding (4-bit slot, 4-bit word). Every bit received at a rising `sck` edge is compared with an arithmetic model.

The padded configuration catches non-zero fill bits and an LSB-aligned word. The unpadded one catches a design that drops the one-bit delay or loads the new pair too early: in that case the last right bit would carry the next frame's data or be lost.

After the source stops, the bench expects the last pair to repeat with `underrun` set. A design that sent zeros there, or never raised the flag, would be reported. The bit-clock period and the ready drop after a transfer are also checked.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/i2s_sck_gen.sv
module i2s_sck_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic sck,
  output logic fall_tick
);
  localparam int unsigned CW = i2s_tx_pkg::bits_for(HALF_DIV);

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          wrap;

  assign wrap      = (cnt_q == CW'(HALF_DIV - 1));
  assign fall_tick = wrap && sck_q;
  assign sck       = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2s_slot_seq.sv
module i2s_slot_seq #(
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned POS_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_tick,
  output logic [POS_W-1:0] pos_next,
  output logic             load_tick,
  output logic             ws
);
  localparam logic [POS_W-1:0] LAST = POS_W'(2 * SLOT_W - 1);

  logic [POS_W-1:0] pos_q;
  logic             ws_q;

  always_comb begin
    pos_next = pos_q;
    if (fall_tick) begin
      pos_next = (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end
  end

  // frame start: the edge that puts the left MSB on the line
  assign load_tick = fall_tick && (pos_next == POS_W'(1));
  assign ws        = ws_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= LAST;
      ws_q  <= i2s_tx_pkg::CH_RIGHT;
    end else if (fall_tick) begin
      pos_q <= pos_next;
      ws_q  <= (pos_next >= POS_W'(SLOT_W)) ? i2s_tx_pkg::CH_RIGHT
                                             : i2s_tx_pkg::CH_LEFT;
    end
  end
endmodule

// File: rtl/i2s_sample_buf.sv
module i2s_sample_buf #(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  input  logic                load_tick,
  output logic [SAMPLE_W-1:0] nxt_left,
  output logic [SAMPLE_W-1:0] nxt_right,
  output logic                underrun
);
  logic [SAMPLE_W-1:0] pend_l, pend_r, cur_l, cur_r;
  logic                pend_v, ur_q, take;

  assign s_ready  = !pend_v;
  assign take     = s_valid && !pend_v;
  assign underrun = ur_q;

  // the word selector needs the pair that is current after this edge
  assign nxt_left  = (load_tick && pend_v) ? pend_l : cur_l;
  assign nxt_right = (load_tick && pend_v) ? pend_r : cur_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l <= '0;
      pend_r <= '0;
      pend_v <= 1'b0;
      cur_l  <= '0;
      cur_r  <= '0;
      ur_q   <= 1'b0;
    end else begin
      if (take) begin
        pend_l <= s_left;
        pend_r <= s_right;
        pend_v <= 1'b1;
      end
      if (load_tick) begin
        if (pend_v) begin
          cur_l  <= pend_l;
          cur_r  <= pend_r;
          pend_v <= 1'b0;
          ur_q   <= 1'b0;
        end else begin
          ur_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2s_bit_sel.sv
module i2s_bit_sel #(
  parameter int unsigned SLOT_W   = 32,
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned POS_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fall_tick,
  input  logic [POS_W-1:0]    pos_next,
  input  logic [SAMPLE_W-1:0] word_l,
  input  logic [SAMPLE_W-1:0] word_r,
  output logic                sd
);
  localparam int unsigned IDX_W = i2s_tx_pkg::bits_for(SAMPLE_W);

  logic [SAMPLE_W-1:0] rev_l, rev_r;
  logic [POS_W-1:0]    q, k;
  logic                is_right, bit_n, sd_q;

  // msb-first views so slot offset k indexes directly
  for (genvar i = 0; i < SAMPLE_W; i++) begin : g_rev
    assign rev_l[i] = word_l[SAMPLE_W-1-i];
    assign rev_r[i] = word_r[SAMPLE_W-1-i];
  end

  always_comb begin
    // one-bit delay: position p carries stream bit p-1
    q        = (pos_next == '0) ? POS_W'(2 * SLOT_W - 1) : pos_next - 1'b1;
    is_right = (q >= POS_W'(SLOT_W));
    k        = is_right ? q - POS_W'(SLOT_W) : q;
    bit_n    = 1'b0;
    if (k < POS_W'(SAMPLE_W)) begin
      bit_n = is_right ? rev_r[k[IDX_W-1:0]] : rev_l[k[IDX_W-1:0]];
    end
  end

  assign sd = sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sd_q <= 1'b0;
    else if (fall_tick) sd_q <= bit_n;
  end
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master #(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned SLOT_W   = 32,
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                sck,
  output logic                ws,
  output logic                sd,
  output logic                underrun
);
  localparam int unsigned POS_W = i2s_tx_pkg::bits_for(2 * SLOT_W);

  logic                fall_tick, load_tick;
  logic [POS_W-1:0]    pos_next;
  logic [SAMPLE_W-1:0] nxt_l, nxt_r;

  i2s_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk(clk), .rst_n(rst_n), .sck(sck), .fall_tick(fall_tick)
  );

  i2s_slot_seq #(.SLOT_W(SLOT_W), .POS_W(POS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick),
    .pos_next(pos_next), .load_tick(load_tick), .ws(ws)
  );

  i2s_sample_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .load_tick(load_tick),
    .nxt_left(nxt_l), .nxt_right(nxt_r), .underrun(underrun)
  );

  i2s_bit_sel #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick), .pos_next(pos_next),
    .word_l(nxt_l), .word_r(nxt_r), .sd(sd)
  );
endmodule

// File: rtl/i2s_tx_master_chk.sv
module i2s_tx_master_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic sck,
  input logic ws,
  input logic sd,
  input logic underrun
);
  assert_ws_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $fell(sck));

  assert_sd_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> $fell(sck));

  assert_flag_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(underrun) |-> $fell(sck));

  assert_fill_drops_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  assert_ws_rise_falls_sck_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ws) |-> !sck);
endmodule

bind i2s_tx_master i2s_tx_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .sck(sck), .ws(ws), .sd(sd), .underrun(underrun)
);

// File: tb/sim_i2s_tx_master.sv
module sim_i2s_tx_master;
  localparam int HALF = 2;
  localparam int W    = 4;
  localparam int S0   = 6;
  localparam int S1   = 4;
  localparam int NP   = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  logic v0 = 1'b0, v1 = 1'b0;
  logic rdy0, rdy1, sck0, sck1, ws0, ws1, sd0, sd1, ur0, ur1;
  logic [W-1:0] dl0 = '0, dr0 = '0, dl1 = '0, dr1 = '0;

  i2s_tx_master #(.HALF_DIV(HALF), .SLOT_W(S0), .SAMPLE_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(v0), .s_ready(rdy0),
    .s_left(dl0), .s_right(dr0), .sck(sck0), .ws(ws0), .sd(sd0), .underrun(ur0)
  );

  i2s_tx_master #(.HALF_DIV(HALF), .SLOT_W(S1), .SAMPLE_W(W)) u1 (
    .clk(clk), .rst_n(rst_n), .s_valid(v1), .s_ready(rdy1),
    .s_left(dl1), .s_right(dr1), .sck(sck1), .ws(ws1), .sd(sd1), .underrun(ur1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int left_of(input int i);
    return (i >> 4) & 15;
  endfunction
  function automatic int right_of(input int i);
    return i & 15;
  endfunction

  // expected sd at stream position t (t = 0 is position 0 of frame 0)
  function automatic int exp_sd(input int t, input int s);
    int q, fb, pi, k, w;
    if (t == 0) return 0;
    q  = (t - 1) % (2 * s);
    fb = (t - 1) / (2 * s);
    pi = (fb < NP) ? fb : NP - 1;
    k  = q % s;
    if (k >= W) return 0;
    w = (q >= s) ? right_of(pi) : left_of(pi);
    return (w >> (W - 1 - k)) & 1;
  endfunction

  function automatic string sd_tag(input int t, input int s);
    int k;
    if (t == 0) return "R4";
    k = ((t - 1) % (2 * s)) % s;
    if (k >= W) return "R6";
    if (k == 0) return "R4";
    return "R5";
  endfunction

  int rc0 = 0, rc1 = 0, last0 = 0, last1 = 0;
  logic p0 = 1'b0, p1 = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sck0 && !p0) begin
        if (rc0 > 0) chk(cyc - last0 == 2 * HALF, "R1 period u0", cyc - last0, 2 * HALF);
        if (rc0 == 0) begin
          chk(ws0 == 1'b1 && sd0 == 1'b0, "R10 first bit u0", {ws0, sd0}, 2);
        end else begin
          int t, p;
          t = rc0 - 1;
          p = t % (2 * S0);
          chk(ws0 == (p >= S0), "R3 ws u0", ws0, p >= S0);
          chk(sd0 == exp_sd(t, S0), sd_tag(t, S0), sd0, exp_sd(t, S0));
          if (p == S0) chk(ur0 == (t / (2 * S0) >= NP), "R9 underrun u0", ur0, t / (2 * S0) >= NP);
        end
        rc0++;
        last0 = cyc;
      end
      if (sck1 && !p1) begin
        if (rc1 > 0) chk(cyc - last1 == 2 * HALF, "R1 period u1", cyc - last1, 2 * HALF);
        if (rc1 == 0) begin
          chk(ws1 == 1'b1 && sd1 == 1'b0, "R10 first bit u1", {ws1, sd1}, 2);
        end else begin
          int t, p;
          t = rc1 - 1;
          p = t % (2 * S1);
          chk(ws1 == (p >= S1), "R3 ws u1", ws1, p >= S1);
          chk(sd1 == exp_sd(t, S1), sd_tag(t, S1), sd1, exp_sd(t, S1));
          if (p == S1) chk(ur1 == (t / (2 * S1) >= NP), "R9 underrun u1", ur1, t / (2 * S1) >= NP);
        end
        rc1++;
        last1 = cyc;
      end
    end
    p0 = sck0;
    p1 = sck1;
  end

  // source for u0; also checks R7 and R8 on the first transfer
  initial begin
    wait (rst_n);
    for (int i = 0; i < NP; i++) begin
      @(negedge clk);
      while (!rdy0) @(negedge clk);
      v0 = 1'b1; dl0 = W'(left_of(i)); dr0 = W'(right_of(i));
      @(negedge clk);
      v0 = 1'b0;
      if (i == 0) chk(rdy0 == 1'b0, "R7 ready low after transfer", rdy0, 0);
      if (i == 1) chk(rdy0 == 1'b0, "R8 second pair held until frame start", rdy0, 0);
    end
  end

  initial begin
    wait (rst_n);
    for (int i = 0; i < NP; i++) begin
      @(negedge clk);
      while (!rdy1) @(negedge clk);
      v1 = 1'b1; dl1 = W'(left_of(i)); dr1 = W'(right_of(i));
      @(negedge clk);
      v1 = 1'b0;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sck0 == 0 && ws0 == 1 && sd0 == 0 && ur0 == 0 && rdy0 == 1,
        "R10 reset state", {sck0, ws0, sd0, ur0, rdy0}, 5'b01001);
    rst_n = 1'b1;
    wait (rc0 > (NP + 3) * 2 * S0 && rc1 > (NP + 3) * 2 * S1);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", rc0, (NP + 3) * 2 * S0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule